// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Transfer Engine

This block moves a block of words between one attached peripheral and system memory so that the processor does not have to copy them itself. Software programs four values through a small register port: a peripheral address, a first memory address, a word count and a direction. It then sets a start bit. The engine asks for the shared bus and waits for a grant. Each word then crosses the bus in a single transaction. Peripheral data goes straight into a memory write, or memory read data goes straight to the peripheral. The data is never staged inside the engine.

The processor always has priority on the bus. When it raises its own request, the engine completes the word already on the bus and then withdraws its request. It asks again once the processor lets go. When the last word has been acknowledged, the engine goes idle and raises an interrupt, which stays high until software clears it.

Top module: `dma_engine`

## Requirements
- R1: After reset the engine is idle and its interrupt, bus request and bus cycle outputs are low. All four register offsets read as zero.
- R2: Register offsets are 0 = peripheral address, 1 = memory address, 2 = word count and 3 = control/status. A control write uses bit0 for direction (0 = peripheral to memory, 1 = memory to peripheral), bit1 for start and bit2 for interrupt clear. A status read returns bit0 = direction, bit1 = busy and bit2 = interrupt. Offsets 1 and 2 read back the current memory address and the remaining count.
- R3: A start with a nonzero count sets busy and raises `bus_req` from the next cycle. No bus cycle (`mem_cyc`) is ever presented without `bus_gnt`.
- R4: Each word takes exactly one bus cycle. In direction 0, `mem_we` is 1, `mem_wdata` equals `dev_rdata`, and `dev_rd_stb` pulses in the acknowledge cycle. In direction 1, `mem_we` is 0, `dev_wdata` equals `mem_rdata`, and `dev_wr_stb` pulses in the acknowledge cycle. `dev_addr` holds the programmed value throughout.
- R5: After each acknowledged word, the memory address grows by DATA_W/8 (4 by default) and the remaining count drops by one.
- R6: While `cpu_req` is high, a word already on the bus still completes. After that the engine keeps `bus_req` low and starts no new word. It raises `bus_req` again once `cpu_req` falls.
- R7: The cycle after the last word is acknowledged, busy is low, the interrupt is high and `bus_req` is low.
- R8: The interrupt stays high until a control write with bit2 set. A control write with bit2 clear leaves it high.
- R9: A start with a count of zero raises the interrupt in the next cycle and never raises `bus_req`.
- R10: While busy, writes to offsets 0, 1 and 2, and to the direction and start bits, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| cpu_req | input | 1 | Processor wants the bus |
| bus_req | output | 1 | Engine bus request |
| bus_gnt | input | 1 | Bus grant to engine |
| mem_cyc | output | 1 | Memory transaction in progress |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Memory transaction acknowledge |
| dev_addr | output | ADDR_W | Programmed peripheral address |
| dev_rdata | input | DATA_W | Peripheral data toward memory |
| dev_rd_stb | output | 1 | Peripheral word consumed |
| dev_wdata | output | DATA_W | Data to peripheral |
| dev_wr_stb | output | 1 | Peripheral word delivered |

## Verification
The assertions make three assumptions about the environment. The arbiter grants only while `bus_req` is high, and it keeps `bus_gnt` up for as long as the engine holds its request. `mem_ack` arrives only during `mem_cyc` and lasts one cycle. The bench arbiter model grants at random only to a request, drops the grant only after the request falls, and acknowledges only a bus cycle it has granted, never twice in a row. The processor request is toggled at random during transfers, so the engine is forced to yield at arbitrary points.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } dma_state_e;

    localparam logic [1:0] OFS_DEV = 2'd0;
    localparam logic [1:0] OFS_MEM = 2'd1;
    localparam logic [1:0] OFS_CNT = 2'd2;
    localparam logic [1:0] OFS_CSR = 2'd3;

    localparam int BIT_DIR  = 0;
    localparam int BIT_GO   = 1;
    localparam int BIT_BUSY = 1;
    localparam int BIT_IRQ  = 2;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              busy,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dir,
    output logic              go,
    output logic              irq_clr,
    output logic              load_mem,
    output logic              load_cnt
);

    typedef struct packed {
        logic [ADDR_W-1:0] dev_addr;
        logic              dir;
    } cfg_t;

    cfg_t cfg_q, cfg_d;
    logic wr_open;
    logic csr_wr;

    always_comb begin
        wr_open  = reg_we && !busy;
        csr_wr   = reg_we && (reg_addr == OFS_CSR);
        load_mem = wr_open && (reg_addr == OFS_MEM);
        load_cnt = wr_open && (reg_addr == OFS_CNT);
        go       = wr_open && (reg_addr == OFS_CSR) && wdata[BIT_GO];
        irq_clr  = csr_wr && wdata[BIT_IRQ];

        cfg_d = cfg_q;
        if (wr_open && (reg_addr == OFS_DEV)) begin
            cfg_d.dev_addr = wdata;
        end
        if (wr_open && (reg_addr == OFS_CSR)) begin
            cfg_d.dir = wdata[BIT_DIR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dev_addr = cfg_q.dev_addr;
    assign dir      = cfg_q.dir;

    // R10: configuration frozen while a transfer runs
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q.dev_addr) && $stable(cfg_q.dir));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_mem,
    input  logic              load_cnt,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  count,
    output logic              cnt_zero,
    output logic              cnt_last
);

    localparam int STEP_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP_BYTES);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        if (load_mem) begin
            seq_d.addr = wdata;
        end
        if (load_cnt) begin
            seq_d.cnt = wdata[CNT_W-1:0];
        end
        if (step) begin
            seq_d.addr = seq_q.addr + ADDR_INC;
            seq_d.cnt  = seq_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr = seq_q.addr;
    assign count    = seq_q.cnt;
    assign cnt_zero = (seq_q.cnt == '0);
    assign cnt_last = (seq_q.cnt == CNT_ONE);

    // R5: one word of address advance per acknowledged transaction
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> seq_q.addr == $past(seq_q.addr) + ADDR_INC);

    // R5: remaining count drops by one per transaction
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> seq_q.cnt == $past(seq_q.cnt) - CNT_ONE);

    // R5: never stepping past an exhausted count
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic irq_clr,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic cpu_req,
    input  logic bus_gnt,
    input  logic mem_ack,
    output logic busy,
    output logic irq,
    output logic bus_req,
    output logic mem_cyc,
    output logic step
);

    typedef struct packed {
        dma_state_e state;
        logic       irq;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (irq_clr) begin
            ctl_d.irq = 1'b0;
        end
        case (ctl_q.state)
            ST_IDLE: begin
                if (go) begin
                    if (cnt_zero) begin
                        ctl_d.irq = 1'b1;
                    end else begin
                        ctl_d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt && !cpu_req) begin
                    ctl_d.state = ST_XFER;
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    if (cnt_last) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.irq   = 1'b1;
                    end else if (cpu_req) begin
                        ctl_d.state = ST_REQ;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, irq: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = (ctl_q.state != ST_IDLE);
    assign irq     = ctl_q.irq;
    assign mem_cyc = (ctl_q.state == ST_XFER);
    assign bus_req = mem_cyc || ((ctl_q.state == ST_REQ) && !cpu_req);
    assign step    = mem_cyc && mem_ack;

    // R3: no transaction without ownership of the bus
    a_r3_cyc_owned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> bus_gnt);

    // R6: a word on the bus is carried to its acknowledge
    a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc && !mem_ack |=> mem_cyc);

    // R6: processor request ends the burst after the current word
    a_r6_yield: assert property (@(posedge clk) disable iff (!rst_n)
        step && cpu_req && !cnt_last |=> !mem_cyc && busy);

    // R7: completion after the final word
    a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
        step && cnt_last |=> irq && !busy && !bus_req);

    // R9: empty transfer completes at once
    a_r9_zero_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && go && cnt_zero |=> irq && !busy);

    // R8: interrupt sticks until cleared
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              cpu_req,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_cyc,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_rd_stb,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_wr_stb
);

    logic              busy;
    logic              dir;
    logic              go;
    logic              irq_clr;
    logic              load_mem;
    logic              load_cnt;
    logic              step;
    logic              cnt_zero;
    logic              cnt_last;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] cfg_wdata;

    assign cfg_wdata = reg_wdata[ADDR_W-1:0];

    dma_regs #(
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .wdata    (cfg_wdata),
        .busy     (busy),
        .dev_addr (dev_addr),
        .dir      (dir),
        .go       (go),
        .irq_clr  (irq_clr),
        .load_mem (load_mem),
        .load_cnt (load_cnt)
    );

    dma_addr_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) i_addr_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_mem (load_mem),
        .load_cnt (load_cnt),
        .wdata    (cfg_wdata),
        .step     (step),
        .mem_addr (mem_addr),
        .count    (count),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    dma_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .irq_clr  (irq_clr),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .cpu_req  (cpu_req),
        .bus_gnt  (bus_gnt),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .irq      (irq),
        .bus_req  (bus_req),
        .mem_cyc  (mem_cyc),
        .step     (step)
    );

    // Single-crossing data path: peripheral and memory face each other directly
    assign mem_we     = mem_cyc && !dir;
    assign mem_wdata  = dev_rdata;
    assign dev_rd_stb = step && !dir;
    assign dev_wdata  = mem_rdata;
    assign dev_wr_stb = step && dir;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DEV: reg_rdata[ADDR_W-1:0] = dev_addr;
            OFS_MEM: reg_rdata[ADDR_W-1:0] = mem_addr;
            OFS_CNT: reg_rdata[CNT_W-1:0]  = count;
            default: begin
                reg_rdata[BIT_DIR]  = dir;
                reg_rdata[BIT_BUSY] = busy;
                reg_rdata[BIT_IRQ]  = irq;
            end
        endcase
    end

    // R4: peripheral address constant while a transfer is in flight
    a_r4_dev_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |=> $stable(dev_addr));

    // R4: exactly one peripheral strobe per acknowledged word
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dev_rd_stb, dev_wr_stb}) == (mem_cyc && mem_ack ? 1 : 0));

endmodule

// File: tb/test_dma_engine.sv
module test_dma_engine;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;
    logic          cpu_req = 1'b0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          mem_cyc;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ack = 1'b0;
    logic [AW-1:0] dev_addr;
    logic [DW-1:0] dev_rdata;
    logic          dev_rd_stb;
    logic [DW-1:0] dev_wdata;
    logic          dev_wr_stb;

    int   n_chk = 0;
    int   n_err = 0;
    logic arb_en = 1'b1;
    logic cpu_noise = 1'b0;
    logic req_seen = 1'b0;
    logic [7:0] tx_id = '0;
    int   src_idx = 0;
    int   sink_n = 0;
    int   wr_seen = 0;
    logic [31:0] mem [64];
    logic [31:0] sink [64];

    always #10 clk = ~clk;

    dma_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .cpu_req(cpu_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_cyc(mem_cyc), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dev_addr(dev_addr), .dev_rdata(dev_rdata), .dev_rd_stb(dev_rd_stb),
        .dev_wdata(dev_wdata), .dev_wr_stb(dev_wr_stb)
    );

    function automatic logic [31:0] dev_pat(logic [7:0] t, int i);
        return {8'hA5, t, 16'(i)};
    endfunction

    function automatic logic [31:0] mem_pat(logic [7:0] t, int i);
        return 32'h5A00_0000 | ({24'd0, t} << 16) | 32'(i * 3 + 1);
    endfunction

    assign mem_rdata = mem[mem_addr[7:2]];
    assign dev_rdata = dev_pat(tx_id, src_idx);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus arbiter, memory acknowledge and processor-request models, then observation
    always @(negedge clk) begin
        logic g;
        logic a;
        if (!rst_n) begin
            bus_gnt = 1'b0;
            mem_ack = 1'b0;
        end else begin
            g = bus_gnt ? bus_req : (arb_en && bus_req && ($urandom_range(0, 3) != 0));
            a = mem_cyc && !mem_ack && bus_gnt && ($urandom_range(0, 2) != 0);
            bus_gnt = g;
            mem_ack = a;
            if (cpu_noise && ($urandom_range(0, 7) == 0)) cpu_req = !cpu_req;
        end
        #1;
        if (rst_n) begin
            if (bus_req) req_seen = 1'b1;
            if (mem_cyc && mem_ack && mem_we) begin
                mem[mem_addr[7:2]] = mem_wdata;
                wr_seen++;
            end
            if (dev_rd_stb) src_idx++;
            if (dev_wr_stb) begin
                sink[sink_n[5:0]] = dev_wdata;
                sink_n++;
            end
            if (mem_cyc && !bus_gnt) begin
                n_chk++; n_err++;
                $display("FAIL R3 bus cycle without grant actual=1 expected=0");
            end
            if (cpu_req && bus_req && !mem_cyc) begin
                n_chk++; n_err++;
                $display("FAIL R6 request while processor owns bus actual=1 expected=0");
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #2;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    task automatic start_xfer(logic d, int base, int cnt, logic [31:0] dv);
        tx_id++;
        src_idx = 0; sink_n = 0; wr_seen = 0;
        for (int k = 0; k < cnt; k++) mem[base + k] = d ? mem_pat(tx_id, k) : 32'hDEAD_BEEF;
        wr(2'd0, dv);
        wr(2'd1, 32'h1000_0000 | 32'(base * 4));
        wr(2'd2, 32'(cnt));
        wr(2'd3, {29'd0, 1'b0, 1'b1, d});
    endtask

    task automatic finish_xfer(logic d, int base, int cnt, logic [31:0] dv);
        logic [31:0] v;
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk); #2; t++;
        end
        chk("R7 irq raised", {31'd0, irq}, 32'd1);
        rd(2'd3, v);
        chk("R7 status idle with irq", v, {29'd0, 1'b1, 1'b0, d});
        chk("R7 bus_req low after done", {31'd0, bus_req}, 32'd0);
        if (!d) begin
            chk("R4 peripheral words consumed", 32'(src_idx), 32'(cnt));
            for (int k = 0; k < cnt; k++)
                chk("R4 memory word from peripheral", mem[base + k], dev_pat(tx_id, k));
        end else begin
            chk("R4 peripheral words delivered", 32'(sink_n), 32'(cnt));
            for (int k = 0; k < cnt; k++)
                chk("R4 peripheral word from memory", sink[k], mem_pat(tx_id, k));
        end
        rd(2'd1, v);
        chk("R5 final memory address", v, 32'h1000_0000 | 32'((base + cnt) * 4));
        rd(2'd2, v);
        chk("R5 remaining count zero", v, 32'd0);
        rd(2'd0, v);
        chk("R2 peripheral address readback", v, dv);
        chk("R4 dev_addr port", dev_addr, dv);
        wr(2'd3, 32'h4);
        chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240917));
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 mem_cyc", {31'd0, mem_cyc}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset value", v, 32'd0);
        end

        // R9: zero count
        req_seen = 1'b0;
        wr(2'd0, 32'h0000_0F00);
        wr(2'd2, 32'd0);
        wr(2'd3, 32'h2);
        chk("R9 irq after zero-count start", {31'd0, irq}, 32'd1);
        rd(2'd3, v);
        chk("R9 status not busy", v, 32'h4);
        repeat (4) @(negedge clk);
        chk("R9 no bus request", {31'd0, req_seen}, 32'd0);
        // R8: sticky interrupt
        wr(2'd3, 32'h0);
        chk("R8 irq held over write without clear", {31'd0, irq}, 32'd1);
        wr(2'd3, 32'h4);
        chk("R8 irq cleared by bit2", {31'd0, irq}, 32'd0);

        // R3 and R10: hold off grant, try writes while busy
        arb_en = 1'b0;
        start_xfer(1'b0, 10, 3, 32'h0000_0C10);
        chk("R3 bus_req after start", {31'd0, bus_req}, 32'd1);
        rd(2'd3, v);
        chk("R3 busy after start", v, 32'h2);
        repeat (5) @(negedge clk);
        #2;
        chk("R3 no bus cycle without grant", {31'd0, mem_cyc}, 32'd0);
        wr(2'd0, 32'h1234_5678);
        wr(2'd1, 32'h0000_0100);
        wr(2'd2, 32'd9);
        wr(2'd3, 32'h3);
        rd(2'd0, v);
        chk("R10 peripheral address write ignored", v, 32'h0000_0C10);
        rd(2'd1, v);
        chk("R10 memory address write ignored", v, 32'h1000_0028);
        rd(2'd2, v);
        chk("R10 count write ignored", v, 32'd3);
        rd(2'd3, v);
        chk("R10 direction write ignored", v, 32'h2);
        arb_en = 1'b1;
        finish_xfer(1'b0, 10, 3, 32'h0000_0C10);

        // R6: processor takes the bus mid-transfer
        start_xfer(1'b1, 20, 5, 32'h0000_0D00);
        while (!mem_cyc) begin
            @(negedge clk); #2;
        end
        cpu_req = 1'b1;
        while (mem_cyc) begin
            @(negedge clk); #2;
        end
        chk("R6 one word finished before yielding", 32'(sink_n), 32'd1);
        chk("R6 request dropped", {31'd0, bus_req}, 32'd0);
        repeat (8) @(negedge clk);
        #2;
        chk("R6 no new word while processor owns bus", 32'(sink_n), 32'd1);
        rd(2'd2, v);
        chk("R5 count after one word", v, 32'd4);
        rd(2'd1, v);
        chk("R5 address after one word", v, 32'h1000_0054);
        @(negedge clk);
        cpu_req = 1'b0;
        #2;
        chk("R6 re-request after release", {31'd0, bus_req}, 32'd1);
        finish_xfer(1'b1, 20, 5, 32'h0000_0D00);

        // Random transfers with processor interference
        cpu_noise = 1'b1;
        for (int n = 0; n < 24; n++) begin
            logic        d  = 1'($urandom_range(0, 1));
            int          b  = int'($urandom_range(0, 47));
            int          c  = int'($urandom_range(1, 16));
            logic [31:0] dv = $urandom;
            start_xfer(d, b, c, dv);
            finish_xfer(d, b, c, dv);
        end
        cpu_noise = 1'b0;
        cpu_req = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule